// File: doc/BRIEF.md
# Dual-Issue Instruction Queue Dispatcher

This block is an in-order instruction queue placed between instruction fetch and two execution resources: one single-stage integer unit and one three-stage floating-point pipeline. Fetch offers up to two instructions per cycle. Each instruction carries a 32-bit word, a class code and a fold flag. The queue keeps its entries compacted toward position 0, so the oldest instruction is always at the head.

Each cycle the dispatcher looks at the two oldest entries in program order and dispatches up to two of them on a two-lane output. Dispatch is limited by the number of free completion-queue slots, by the one-instruction-per-unit-per-cycle limit of each unit, and by a floating-point hazard rule. The hazard rule blocks floating-point dispatch for one cycle after all three pipeline stages were seen occupied. An unconditional taken branch that writes no link or count register is marked foldable. Such a branch is dropped from the queue without using a lane or a completion slot. A flush input empties the queue when fetch is redirected.

Top module: `iq_dual_dispatch`

## Requirements
- R1: While reset is asserted and after it is released, the queue is empty: both dispatch lanes are invalid and fetch_rdy_o is high.
- R2: fetch_rdy_o is high exactly when at least two of the six entries are free. fetch_cnt_i (0, 1 or 2; 3 counts as 2) is accepted at a clock edge only when fetch_rdy_o is high. Otherwise the offered instructions are discarded.
- R3: Dispatch follows program order. If the oldest entry cannot dispatch, no younger entry dispatches in that cycle. When both lanes are valid, lane 0 carries the older instruction.
- R4: The number of valid lanes never exceeds cq_free_i (cq_free_i of 2 or 3 allows two).
- R5: At most one integer-class instruction (class 0) dispatches per cycle. Of two consecutive integer instructions, the second leaves one cycle later.
- R6: At most one floating-point instruction (class 1) dispatches per cycle. No floating-point instruction dispatches in the cycle that follows a clock edge at which all bits of fpu_busy_i were 1.
- R7: A class 2 entry with its fold flag set is removed at the next clock edge. It appears on no lane, uses no completion slot, and does not block a younger entry behind it.
- R8: Entries that are not removed move toward position 0, keeping their order. New fetches are placed behind them, with fetch lane 0 older than fetch lane 1.
- R9: flush_i empties the queue at the next edge. Instructions offered on fetch in that same cycle are discarded.
- R10: A class 2 entry without the fold flag (and class 3) dispatches like any other instruction and needs only a completion slot. Two of them may dispatch together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the queue (redirect) |
| fetch_cnt_i | input | 2 | Number of valid fetch lanes |
| fetch_cls_i | input | 2x2 | Class per fetch lane: 0 integer, 1 float, 2 branch |
| fetch_fold_i | input | 2 | Branch is unconditional, taken, no link/count write |
| fetch_word_i | input | 2x32 | Instruction words, lane 0 older |
| fetch_rdy_o | output | 1 | At least two queue entries free |
| cq_free_i | input | 2 | Free completion-queue slots this cycle |
| fpu_busy_i | input | 3 | Occupancy of the floating-point stages |
| disp_vld_o | output | 2 | Lane carries a dispatched instruction |
| disp_cls_o | output | 2x2 | Class of each lane |
| disp_word_o | output | 2x32 | Instruction word of each lane |

## Verification
The hardest case to reach is the floating-point hold. A floating-point instruction must already be at the head when the full-pipeline observation takes effect, and no completion slot may let it dispatch before that. The bench loads the queue while cq_free_i is 0 and fpu_busy_i is all ones. It then opens completion slots and clears the busy bits in the same cycle. It expects both lanes to stay idle for that cycle, with an integer instruction stalled behind the held one, and expects both to leave one cycle later. Folding is shown the same way. The completion slots are kept at zero so that only the branch can leave, and the next head is then read on the lanes.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_FP  = 2'd1,
    CLS_BR  = 2'd2,
    CLS_RSV = 2'd3
  } iq_cls_e;

  typedef struct packed {
    iq_cls_e cls;
    logic    fold;
  } iq_tag_t;

  localparam int unsigned LANES = 2;
endpackage

// File: rtl/iq_fp_hazard.sv
module iq_fp_hazard #(
  parameter int unsigned STAGES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAGES-1:0] fpu_busy_i,
  output logic              hold_o
);
  logic hold_q;

  // full pipeline seen at this edge blocks float dispatch next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= &fpu_busy_i;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/iq_store.sv
module iq_store
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned IW    = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic [1:0]               pop_i,
  input  logic [1:0]               push_n_i,
  input  iq_tag_t [LANES-1:0]      push_tag_i,
  input  logic [LANES-1:0][IW-1:0] push_word_i,
  output logic [CNT_W-1:0]         count_o,
  output logic [LANES-1:0]         head_vld_o,
  output iq_tag_t [LANES-1:0]      head_tag_o,
  output logic [LANES-1:0][IW-1:0] head_word_o
);
  iq_tag_t [DEPTH-1:0]      tag_q, tag_d;
  logic [DEPTH-1:0][IW-1:0] word_q, word_d;
  logic [CNT_W-1:0]         count_q, count_d;

  always_comb begin
    int keep;
    int src;
    int fi;
    keep    = int'(count_q) - int'(pop_i);
    tag_d   = tag_q;
    word_d  = word_q;
    for (int j = 0; j < int'(DEPTH); j++) begin
      src = j + int'(pop_i);
      fi  = j - keep;
      if (j < keep && src < int'(DEPTH)) begin
        tag_d[j]  = tag_q[src[IDX_W-1:0]];
        word_d[j] = word_q[src[IDX_W-1:0]];
      end else if (fi >= 0 && fi < int'(push_n_i)) begin
        tag_d[j]  = push_tag_i[fi[0]];
        word_d[j] = push_word_i[fi[0]];
      end
    end
    if (flush_i) count_d = '0;
    else         count_d = CNT_W'(keep + int'(push_n_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      tag_q   <= '0;
      word_q  <= '0;
    end else begin
      count_q <= count_d;
      tag_q   <= tag_d;
      word_q  <= word_d;
    end
  end

  for (genvar g = 0; g < int'(LANES); g++) begin : g_head
    assign head_vld_o[g]  = count_q > CNT_W'(g);
    assign head_tag_o[g]  = tag_q[g];
    assign head_word_o[g] = word_q[g];
  end

  assign count_o = count_q;

  assert_no_overflow_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));

  assert_flush_empty_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_q == '0);

  assert_pop_bounded_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pop_i) <= int'(count_q));
endmodule

// File: rtl/iq_issue_sel.sv
module iq_issue_sel
  import iq_pkg::*;
#(
  parameter int unsigned IW = 32
) (
  input  logic [LANES-1:0]         head_vld_i,
  input  iq_tag_t [LANES-1:0]      head_tag_i,
  input  logic [LANES-1:0][IW-1:0] head_word_i,
  input  logic [1:0]               cq_free_i,
  input  logic                     fp_hold_i,
  output logic [1:0]               pop_o,
  output logic [LANES-1:0]         lane_vld_o,
  output logic [LANES-1:0][1:0]    lane_cls_o,
  output logic [LANES-1:0][IW-1:0] lane_word_o
);
  always_comb begin
    logic       go;
    logic       ok;
    logic       int_used;
    logic       fp_used;
    logic       lane_n;
    logic [1:0] cq_used;
    logic [1:0] cq_lim;
    go          = 1'b1;
    int_used    = 1'b0;
    fp_used     = 1'b0;
    lane_n      = 1'b0;
    cq_used     = 2'd0;
    cq_lim      = (cq_free_i >= 2'd2) ? 2'd2 : cq_free_i;
    pop_o       = 2'd0;
    lane_vld_o  = '0;
    lane_cls_o  = '0;
    lane_word_o = '0;
    for (int i = 0; i < int'(LANES); i++) begin
      ok = 1'b0;
      if (go && head_vld_i[i]) begin
        if (head_tag_i[i].cls == CLS_BR && head_tag_i[i].fold) begin
          pop_o = pop_o + 2'd1;  // folded: no lane, no slot
        end else begin
          ok = cq_used < cq_lim;
          if (head_tag_i[i].cls == CLS_INT) ok = ok && !int_used;
          if (head_tag_i[i].cls == CLS_FP)  ok = ok && !fp_used && !fp_hold_i;
          if (ok) begin
            pop_o   = pop_o + 2'd1;
            cq_used = cq_used + 2'd1;
            if (head_tag_i[i].cls == CLS_INT) int_used = 1'b1;
            if (head_tag_i[i].cls == CLS_FP)  fp_used  = 1'b1;
            if (!lane_n) begin
              lane_vld_o[0]  = 1'b1;
              lane_cls_o[0]  = head_tag_i[i].cls;
              lane_word_o[0] = head_word_i[i];
            end else begin
              lane_vld_o[1]  = 1'b1;
              lane_cls_o[1]  = head_tag_i[i].cls;
              lane_word_o[1] = head_word_i[i];
            end
            lane_n = 1'b1;
          end else begin
            go = 1'b0;  // in-order: stall blocks younger
          end
        end
      end else begin
        go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/iq_dual_dispatch.sv
module iq_dual_dispatch
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH      = 6,
  parameter int unsigned IW         = 32,
  parameter int unsigned FPU_STAGES = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic [1:0]            fetch_cnt_i,
  input  logic [1:0][1:0]       fetch_cls_i,
  input  logic [1:0]            fetch_fold_i,
  input  logic [1:0][IW-1:0]    fetch_word_i,
  output logic                  fetch_rdy_o,
  input  logic [1:0]            cq_free_i,
  input  logic [FPU_STAGES-1:0] fpu_busy_i,
  output logic [1:0]            disp_vld_o,
  output logic [1:0][1:0]       disp_cls_o,
  output logic [1:0][IW-1:0]    disp_word_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]         count;
  logic [LANES-1:0]         head_vld;
  iq_tag_t [LANES-1:0]      head_tag;
  logic [LANES-1:0][IW-1:0] head_word;
  iq_tag_t [LANES-1:0]      push_tag;
  logic [1:0]               pop_n;
  logic [1:0]               push_n;
  logic                     fp_hold;

  assign fetch_rdy_o = (int'(DEPTH) - int'(count)) >= 2;
  assign push_n      = (fetch_rdy_o && !flush_i) ?
                       ((fetch_cnt_i > 2'd2) ? 2'd2 : fetch_cnt_i) : 2'd0;

  for (genvar g = 0; g < int'(LANES); g++) begin : g_tag
    assign push_tag[g].cls  = iq_cls_e'(fetch_cls_i[g]);
    assign push_tag[g].fold = fetch_fold_i[g];
  end

  iq_fp_hazard #(.STAGES(FPU_STAGES)) u_hazard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fpu_busy_i (fpu_busy_i),
    .hold_o     (fp_hold)
  );

  iq_store #(.DEPTH(DEPTH), .IW(IW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .pop_i       (pop_n),
    .push_n_i    (push_n),
    .push_tag_i  (push_tag),
    .push_word_i (fetch_word_i),
    .count_o     (count),
    .head_vld_o  (head_vld),
    .head_tag_o  (head_tag),
    .head_word_o (head_word)
  );

  iq_issue_sel #(.IW(IW)) u_sel (
    .head_vld_i  (head_vld),
    .head_tag_i  (head_tag),
    .head_word_i (head_word),
    .cq_free_i   (cq_free_i),
    .fp_hold_i   (fp_hold),
    .pop_o       (pop_n),
    .lane_vld_o  (disp_vld_o),
    .lane_cls_o  (disp_cls_o),
    .lane_word_o (disp_word_o)
  );

  assert_lane_order_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_vld_o[1] |-> disp_vld_o[0]);

  assert_cq_limit_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(disp_vld_o) <= ((cq_free_i >= 2'd2) ? 2 : int'(cq_free_i)));

  assert_one_int_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&disp_vld_o && disp_cls_o[0] == 2'd0 && disp_cls_o[1] == 2'd0));

  assert_one_fp_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&disp_vld_o && disp_cls_o[0] == 2'd1 && disp_cls_o[1] == 2'd1));

  assert_fp_hold_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&fpu_busy_i) |=> !((disp_vld_o[0] && disp_cls_o[0] == 2'd1) ||
                        (disp_vld_o[1] && disp_cls_o[1] == 2'd1)));

  assert_fetch_ignored_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_rdy_o && !flush_i) |=> int'(count) <= int'($past(count)));
endmodule

// File: tb/tb_iq_dual_dispatch.sv
module tb_iq_dual_dispatch;
  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            flush_i = 1'b0;
  logic [1:0]      fetch_cnt_i = '0;
  logic [1:0][1:0] fetch_cls_i = '0;
  logic [1:0]      fetch_fold_i = '0;
  logic [1:0][31:0] fetch_word_i = '0;
  logic            fetch_rdy_o;
  logic [1:0]      cq_free_i = '0;
  logic [2:0]      fpu_busy_i = '0;
  logic [1:0]      disp_vld_o;
  logic [1:0][1:0] disp_cls_o;
  logic [1:0][31:0] disp_word_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  iq_dual_dispatch dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .fetch_cnt_i(fetch_cnt_i), .fetch_cls_i(fetch_cls_i),
    .fetch_fold_i(fetch_fold_i), .fetch_word_i(fetch_word_i),
    .fetch_rdy_o(fetch_rdy_o), .cq_free_i(cq_free_i),
    .fpu_busy_i(fpu_busy_i), .disp_vld_o(disp_vld_o),
    .disp_cls_o(disp_cls_o), .disp_word_o(disp_word_o)
  );

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk_lane(int ln, logic ev, logic [1:0] ec, logic [31:0] ew, string req);
    #1;
    n_chk++;
    if (disp_vld_o[ln] !== ev ||
        (ev && (disp_cls_o[ln] !== ec || disp_word_o[ln] !== ew))) begin
      n_bad++;
      $display("FAIL %s lane%0d: got v=%0b c=%0d w=%h, exp v=%0b c=%0d w=%h",
               req, ln, disp_vld_o[ln], disp_cls_o[ln], disp_word_o[ln], ev, ec, ew);
    end
  endtask

  task automatic chk_rdy(logic exp, string req);
    #1;
    n_chk++;
    if (fetch_rdy_o !== exp) begin
      n_bad++;
      $display("FAIL %s fetch_rdy: got %0b, exp %0b", req, fetch_rdy_o, exp);
    end
  endtask

  task automatic fetch(int n, logic [1:0] c0, logic f0, logic [31:0] w0,
                       logic [1:0] c1, logic f1, logic [31:0] w1);
    fetch_cnt_i     = 2'(n);
    fetch_cls_i[0]  = c0; fetch_fold_i[0] = f0; fetch_word_i[0] = w0;
    fetch_cls_i[1]  = c1; fetch_fold_i[1] = f1; fetch_word_i[1] = w1;
    step();
    fetch_cnt_i = 2'd0;
  endtask

  task automatic t_reset();
    chk_lane(0, 1'b0, 0, 0, "R1");
    chk_lane(1, 1'b0, 0, 0, "R1");
    chk_rdy(1'b1, "R1");
  endtask

  task automatic t_int_pair();
    cq_free_i = 2'd0;
    fetch(2, 2'd0, 0, 32'hA0, 2'd0, 0, 32'hA1);
    chk_lane(0, 1'b0, 0, 0, "R4");
    cq_free_i = 2'd2;
    chk_lane(0, 1'b1, 2'd0, 32'hA0, "R5");
    chk_lane(1, 1'b0, 0, 0, "R5");
    step();
    chk_lane(0, 1'b1, 2'd0, 32'hA1, "R8");
    chk_lane(1, 1'b0, 0, 0, "R8");
    step();
    chk_lane(0, 1'b0, 0, 0, "R8");
  endtask

  task automatic t_int_fp();
    cq_free_i = 2'd0;
    fetch(2, 2'd0, 0, 32'hC0, 2'd1, 0, 32'hC1);
    cq_free_i = 2'd1;
    chk_lane(0, 1'b1, 2'd0, 32'hC0, "R4");
    chk_lane(1, 1'b0, 0, 0, "R4");
    step();
    chk_lane(0, 1'b1, 2'd1, 32'hC1, "R8");
    step();
    cq_free_i = 2'd0;
    fetch(2, 2'd0, 0, 32'hE0, 2'd1, 0, 32'hE1);
    cq_free_i = 2'd3;
    chk_lane(0, 1'b1, 2'd0, 32'hE0, "R3");
    chk_lane(1, 1'b1, 2'd1, 32'hE1, "R3");
    step();
    chk_lane(0, 1'b0, 0, 0, "R3");
  endtask

  task automatic t_fp_rules();
    cq_free_i = 2'd0;
    fpu_busy_i = 3'b111;
    fetch(2, 2'd1, 0, 32'hF0, 2'd0, 0, 32'hF1);
    fpu_busy_i = 3'b000;
    cq_free_i = 2'd2;
    chk_lane(0, 1'b0, 0, 0, "R6");
    chk_lane(1, 1'b0, 0, 0, "R3");
    step();
    chk_lane(0, 1'b1, 2'd1, 32'hF0, "R6");
    chk_lane(1, 1'b1, 2'd0, 32'hF1, "R6");
    step();
    cq_free_i = 2'd0;
    fetch(2, 2'd1, 0, 32'hD0, 2'd1, 0, 32'hD1);
    cq_free_i = 2'd2;
    chk_lane(0, 1'b1, 2'd1, 32'hD0, "R6");
    chk_lane(1, 1'b0, 0, 0, "R6");
    step();
    chk_lane(0, 1'b1, 2'd1, 32'hD1, "R6");
    step();
  endtask

  task automatic t_fold();
    cq_free_i = 2'd0;
    fetch(2, 2'd2, 1, 32'hB0, 2'd0, 0, 32'hB1);
    chk_lane(0, 1'b0, 0, 0, "R7");
    step();
    cq_free_i = 2'd2;
    chk_lane(0, 1'b1, 2'd0, 32'hB1, "R7");
    chk_lane(1, 1'b0, 0, 0, "R7");
    step();
    cq_free_i = 2'd0;
    fetch(2, 2'd0, 0, 32'hB2, 2'd2, 1, 32'hB3);
    cq_free_i = 2'd2;
    chk_lane(0, 1'b1, 2'd0, 32'hB2, "R7");
    chk_lane(1, 1'b0, 0, 0, "R7");
    step();
    chk_lane(0, 1'b0, 0, 0, "R7");
  endtask

  task automatic t_fill();
    cq_free_i = 2'd0;
    chk_rdy(1'b1, "R2");
    fetch(2, 2'd0, 0, 32'h10, 2'd1, 0, 32'h11);
    fetch(2, 2'd0, 0, 32'h12, 2'd1, 0, 32'h13);
    chk_rdy(1'b1, "R2");
    fetch(1, 2'd0, 0, 32'h14, 2'd0, 0, 32'h0);
    chk_rdy(1'b0, "R2");
    fetch(2, 2'd0, 0, 32'h15, 2'd0, 0, 32'h16);
    chk_rdy(1'b0, "R2");
    cq_free_i = 2'd2;
    chk_lane(0, 1'b1, 2'd0, 32'h10, "R8");
    chk_lane(1, 1'b1, 2'd1, 32'h11, "R8");
    step();
    chk_lane(0, 1'b1, 2'd0, 32'h12, "R8");
    chk_lane(1, 1'b1, 2'd1, 32'h13, "R8");
    step();
    chk_lane(0, 1'b1, 2'd0, 32'h14, "R2");
    chk_lane(1, 1'b0, 0, 0, "R2");
    step();
    chk_lane(0, 1'b0, 0, 0, "R2");
    chk_rdy(1'b1, "R2");
  endtask

  task automatic t_flush();
    cq_free_i = 2'd0;
    fetch(2, 2'd0, 0, 32'h50, 2'd0, 0, 32'h51);
    flush_i = 1'b1;
    fetch(2, 2'd0, 0, 32'h52, 2'd0, 0, 32'h53);
    flush_i = 1'b0;
    cq_free_i = 2'd2;
    chk_lane(0, 1'b0, 0, 0, "R9");
    chk_rdy(1'b1, "R9");
  endtask

  task automatic t_plain_branch();
    cq_free_i = 2'd0;
    fetch(2, 2'd2, 0, 32'h70, 2'd3, 0, 32'h71);
    chk_lane(0, 1'b0, 0, 0, "R10");
    cq_free_i = 2'd2;
    chk_lane(0, 1'b1, 2'd2, 32'h70, "R10");
    chk_lane(1, 1'b1, 2'd3, 32'h71, "R10");
    step();
    chk_lane(0, 1'b0, 0, 0, "R10");
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_int_pair();
    t_int_fp();
    t_fp_rules();
    t_fold();
    t_fill();
    t_flush();
    t_plain_branch();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, exp completion");
    summary();
    $finish;
  end
endmodule